// File: doc/BRIEF.md
# Multi-Phase Instruction Fetch Sequencer

This block steps a 16-bit CPU through the fetch and execute of variable-length instructions. An instruction is one word long. It may be followed by a second word that holds a constant. A two-bit phase register moves through three states:

- **Fetch:** the word at the program counter is latched as the instruction.
- **Constant fetch:** taken only when the most significant opcode bit of the instruction is set. The following word is latched as the constant.
- **Execute:** the program counter either keeps its value, which already points at the next instruction, or takes a branch target supplied by the datapath.

The program counter drives the memory address at all times. It advances by one word after each fetch.

Interrupts are taken only at the end of the execute phase, and only while the one-bit interrupt flag is clear. When an interrupt is taken:

- the block asks for the resume address to be written into register 6;
- the program counter jumps to a fixed vector;
- the flag is set.

An interrupt-return strobe given during execute clears the flag. Instruction decode beyond the constant-needed bit, and the ALU, belong to other blocks.

Top module: `fetch_sequencer`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and on the first cycle after it is released, the phase is 0 and the program counter is 0. The interrupt flag, the instruction register and the constant register are all 0.
- R2: In phase 0 the memory address equals the program counter. At the next clock edge the instruction register takes `mem_rdata` and the program counter increments by one.
- R3: If bit 15 of the fetched instruction is 1, phase 0 is followed by phase 1. In phase 1 the constant register takes `mem_rdata`, the program counter increments by one, and the next phase is 2.
- R4: If bit 15 of the fetched instruction is 0, phase 0 is followed directly by phase 2, and the constant register keeps its value. The instruction register changes only in phase 0.
- R5: In phase 2 with `branch_taken` low and no interrupt taken, the program counter keeps its value and the next phase is 0.
- R6: In phase 2 with `branch_taken` high and no interrupt taken, the program counter loads `branch_target`.
- R7: In phase 2, with `irq_req` high and the interrupt flag clear, the interrupt is taken. During that cycle `ret_wr_en` is 1, `ret_wr_addr` is 6, and `ret_wr_data` is the address execution would otherwise resume at (the branch target if a branch is taken, else the program counter). At the next edge the program counter becomes the vector 0x0010 and the flag is set.
- R8: `irq_req` has no effect outside phase 2 or while the interrupt flag is set: `ret_wr_en` stays 0, and neither the program counter nor the flag is changed by it.
- R9: `irq_return` clears the interrupt flag only in phase 2. Outside phase 2 it has no effect. A request that arrives in the same cycle as a return is not taken.
- R10: `branch_taken` and `branch_target` have no effect outside phase 2.
- R11: The program counter wraps from 0xFFFF to 0x0000 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address for program memory (the program counter) |
| mem_rdata | input | 16 | Word read from program memory at `mem_addr`, same cycle |
| branch_taken | input | 1 | Execute-phase request to load `branch_target` |
| branch_target | input | 16 | Address loaded into the program counter on a taken branch |
| irq_req | input | 1 | Interrupt request level |
| irq_return | input | 1 | Execute-phase strobe that ends interrupt service |
| phase | output | 2 | Current phase: 0 fetch, 1 constant fetch, 2 execute |
| instr | output | 16 | Instruction register |
| const_word | output | 16 | Constant register |
| pc | output | 16 | Program counter |
| irq_flag | output | 1 | Set while an interrupt is being serviced |
| ret_wr_en | output | 1 | Write request for the resume address |
| ret_wr_addr | output | 3 | Register index for the resume address (6) |
| ret_wr_data | output | 16 | Resume address to be saved |

## Verification
The assertions assume that memory answers in the same cycle with the word at `mem_addr`. They also assume that the branch and return controls are meaningful only in execute, so the properties tie every state change to the phase in which it may occur. The stimulus uses a small combinational memory model. It drives the controls between clock edges, including deliberate assertion of branch, interrupt and return during fetch phases, so that the blocking rules are exercised without ever producing an illegal phase.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_CONST = 2'd1,
    PH_EXEC  = 2'd2,
    PH_SPARE = 2'd3
  } phase_e;

  // Phase successor: the spare code falls back to fetch.
  function automatic phase_e phase_after(phase_e cur, logic want_const);
    case (cur)
      PH_FETCH: phase_after = want_const ? PH_CONST : PH_EXEC;
      PH_CONST: phase_after = PH_EXEC;
      PH_EXEC:  phase_after = PH_FETCH;
      default:  phase_after = PH_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/fseq_phase_ctrl.sv
module fseq_phase_ctrl
  import fseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   want_const,
  output phase_e cur_phase,
  output logic   fetch_ev,
  output logic   const_ev,
  output logic   exec_ev
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_after(phase_q, want_const);
  end

  assign cur_phase = phase_q;
  assign fetch_ev  = (phase_q == PH_FETCH);
  assign const_ev  = (phase_q == PH_CONST);
  assign exec_ev   = (phase_q == PH_EXEC);

endmodule

// File: rtl/fseq_word_regs.sv
module fseq_word_regs #(
  parameter int WORD_W   = 16,
  parameter int N_SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOTS-1:0] load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout [N_SLOTS]
);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '0;
      else if (load[s]) word_q <= din;
    end
    assign dout[s] = word_q;
  end

endmodule

// File: rtl/fseq_pc_unit.sv
module fseq_pc_unit #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [ADDR_W-1:0] IRQ_VECTOR = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_ev,
  input  logic              const_ev,
  input  logic              exec_ev,
  input  logic              irq_take,
  input  logic              branch_taken,
  input  logic [ADDR_W-1:0] branch_target,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] resume_pc
);

  function automatic logic [ADDR_W-1:0] next_word(logic [ADDR_W-1:0] a);
    next_word = a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] exec_dest(logic tk, logic [ADDR_W-1:0] tgt,
                                                  logic [ADDR_W-1:0] cur);
    exec_dest = tk ? tgt : cur;
  endfunction

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  assign resume_pc = exec_dest(branch_taken, branch_target, pc_q);

  always_comb begin
    pc_d = pc_q;
    if (fetch_ev || const_ev) pc_d = next_word(pc_q);
    else if (exec_ev)         pc_d = irq_take ? IRQ_VECTOR : resume_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

endmodule

// File: rtl/fseq_irq_ctrl.sv
module fseq_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_ev,
  input  logic irq_req,
  input  logic irq_return,
  output logic irq_flag,
  output logic irq_take
);

  logic flag_q;

  assign irq_take = exec_ev && irq_req && !flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (irq_take)             flag_q <= 1'b1;
    else if (exec_ev && irq_return) flag_q <= 1'b0;
  end

  assign irq_flag = flag_q;

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer #(
  parameter int                 WORD_W         = 16,
  parameter int                 CONST_FLAG_BIT = 15,
  parameter int                 REG_IDX_W      = 3,
  parameter logic [REG_IDX_W-1:0] LINK_REG     = 3'd6,
  parameter logic [WORD_W-1:0]  RESET_PC       = '0,
  parameter logic [WORD_W-1:0]  IRQ_VECTOR     = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [WORD_W-1:0]    mem_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic                 branch_taken,
  input  logic [WORD_W-1:0]    branch_target,
  input  logic                 irq_req,
  input  logic                 irq_return,
  output logic [1:0]           phase,
  output logic [WORD_W-1:0]    instr,
  output logic [WORD_W-1:0]    const_word,
  output logic [WORD_W-1:0]    pc,
  output logic                 irq_flag,
  output logic                 ret_wr_en,
  output logic [REG_IDX_W-1:0] ret_wr_addr,
  output logic [WORD_W-1:0]    ret_wr_data
);
  import fseq_pkg::*;

  localparam int SLOT_INSTR = 0;
  localparam int SLOT_CONST = 1;
  localparam int N_SLOTS    = 2;

  phase_e            cur_phase;
  logic              fetch_ev, const_ev, exec_ev;
  logic              irq_take;
  logic              want_const;
  logic [WORD_W-1:0] resume_pc;
  logic [WORD_W-1:0] slot_q [N_SLOTS];
  logic [N_SLOTS-1:0] slot_load;

  assign want_const = mem_rdata[CONST_FLAG_BIT];

  fseq_phase_ctrl i_phase (
    .clk(clk), .rst_n(rst_n), .want_const(want_const),
    .cur_phase(cur_phase), .fetch_ev(fetch_ev), .const_ev(const_ev), .exec_ev(exec_ev)
  );

  always_comb begin
    slot_load = '0;
    slot_load[SLOT_INSTR] = fetch_ev;
    slot_load[SLOT_CONST] = const_ev;
  end

  fseq_word_regs #(.WORD_W(WORD_W), .N_SLOTS(N_SLOTS)) i_words (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .din(mem_rdata), .dout(slot_q)
  );

  fseq_irq_ctrl i_irq (
    .clk(clk), .rst_n(rst_n), .exec_ev(exec_ev), .irq_req(irq_req),
    .irq_return(irq_return), .irq_flag(irq_flag), .irq_take(irq_take)
  );

  fseq_pc_unit #(.ADDR_W(WORD_W), .RESET_PC(RESET_PC), .IRQ_VECTOR(IRQ_VECTOR)) i_pc (
    .clk(clk), .rst_n(rst_n), .fetch_ev(fetch_ev), .const_ev(const_ev), .exec_ev(exec_ev),
    .irq_take(irq_take), .branch_taken(branch_taken), .branch_target(branch_target),
    .pc(pc), .resume_pc(resume_pc)
  );

  assign mem_addr    = pc;
  assign phase       = cur_phase;
  assign instr       = slot_q[SLOT_INSTR];
  assign const_word  = slot_q[SLOT_CONST];
  assign ret_wr_en   = irq_take;
  assign ret_wr_addr = LINK_REG;
  assign ret_wr_data = resume_pc;

endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
  parameter int                WORD_W     = 16,
  parameter logic [WORD_W-1:0] IRQ_VECTOR = 16'h0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        phase,
  input logic [WORD_W-1:0] pc,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] const_word,
  input logic              irq_flag,
  input logic              irq_req,
  input logic              ret_wr_en,
  input logic              exec_ev,
  input logic              irq_take
);

  p_fetch_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> (phase == 2'd1 || phase == 2'd2));

  p_const_to_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |=> (phase == 2'd2));

  p_exec_to_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> (phase == 2'd0));

  p_fetch_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> (pc == $past(pc) + WORD_W'(1)));

  p_addr_is_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr == pc);

  p_instr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |=> $stable(instr));

  p_const_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd1) |=> $stable(const_word));

  p_take_in_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_wr_en |-> (exec_ev && irq_req && phase == 2'd2));

  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (pc == IRQ_VECTOR && irq_flag));

  p_flag_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |-> !ret_wr_en);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |=> $stable(irq_flag));

endmodule

bind fetch_sequencer fetch_sequencer_chk #(.WORD_W(WORD_W), .IRQ_VECTOR(IRQ_VECTOR)) i_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .pc(pc), .mem_addr(mem_addr),
  .instr(instr), .const_word(const_word), .irq_flag(irq_flag), .irq_req(irq_req),
  .ret_wr_en(ret_wr_en), .exec_ev(exec_ev), .irq_take(irq_take)
);

// File: tb/test_fetch_sequencer.sv
`timescale 1ns/1ps
module test_fetch_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr, mem_rdata;
  logic        branch_taken;
  logic [15:0] branch_target;
  logic        irq_req, irq_return;
  logic [1:0]  phase;
  logic [15:0] instr, const_word, pc;
  logic        irq_flag, ret_wr_en;
  logic [2:0]  ret_wr_addr;
  logic [15:0] ret_wr_data;

  logic [15:0] mem [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  fetch_sequencer i_fetch_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .branch_taken(branch_taken), .branch_target(branch_target),
    .irq_req(irq_req), .irq_return(irq_return), .phase(phase), .instr(instr),
    .const_word(const_word), .pc(pc), .irq_flag(irq_flag), .ret_wr_en(ret_wr_en),
    .ret_wr_addr(ret_wr_addr), .ret_wr_data(ret_wr_data)
  );

  localparam logic [15:0] VEC = 16'h0010;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_ctrl();
    branch_taken = 1'b0; branch_target = '0; irq_req = 1'b0; irq_return = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_ctrl();
    step(); step();
    chk("R1", "phase in reset", phase, 0);
    rst_n = 1'b1;
    step();
    // one fetch has happened already; check state before it via fresh reset
    rst_n = 1'b0;
    step();
    chk("R1", "phase", phase, 0);
    chk("R1", "pc", pc, 0);
    chk("R1", "flag", irq_flag, 0);
    chk("R1", "instr", instr, 0);
    chk("R1", "const", const_word, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_short();
    mem[0] = 16'h1234;
    chk("R2", "addr at fetch", mem_addr, 0);
    step();
    chk("R2", "instr loaded", instr, 16'h1234);
    chk("R2", "pc inc", pc, 1);
    chk("R4", "skip to exec", phase, 2);
    chk("R4", "const kept", const_word, 0);
    step();
    chk("R5", "pc held", pc, 1);
    chk("R5", "back to fetch", phase, 0);
  endtask

  task automatic t_long();
    mem[1] = 16'h8A05; mem[2] = 16'hBEEF;
    step();
    chk("R3", "const phase", phase, 1);
    chk("R3", "instr", instr, 16'h8A05);
    chk("R3", "pc", pc, 2);
    step();
    chk("R3", "exec", phase, 2);
    chk("R3", "const loaded", const_word, 16'hBEEF);
    chk("R3", "pc", pc, 3);
    chk("R4", "instr held", instr, 16'h8A05);
    branch_taken = 1'b1; branch_target = 16'h0020;
    step();
    idle_ctrl();
    chk("R6", "branch pc", pc, 16'h0020);
    chk("R6", "fetch", phase, 0);
  endtask

  task automatic t_ignored_outside_exec();
    mem[32] = 16'h8001; mem[33] = 16'h0042;
    branch_taken = 1'b1; branch_target = 16'h0005; irq_req = 1'b1; irq_return = 1'b1;
    chk("R8", "no take in fetch", ret_wr_en, 0);
    step();
    chk("R10", "branch ignored", pc, 16'h0021);
    chk("R8", "flag untouched", irq_flag, 0);
    chk("R8", "no take in const", ret_wr_en, 0);
    step();
    chk("R10", "branch ignored const", pc, 16'h0022);
    chk("R3", "const", const_word, 16'h0042);
    idle_ctrl();
  endtask

  task automatic t_irq();
    mem[16] = 16'h0007; mem[17] = 16'h0003; mem[18] = 16'h0000;
    irq_req = 1'b1;
    #0;
    chk("R7", "ret_wr_en", ret_wr_en, 1);
    chk("R7", "ret_wr_addr", ret_wr_addr, 6);
    chk("R7", "ret_wr_data", ret_wr_data, 16'h0022);
    step();
    chk("R7", "vector", pc, VEC);
    chk("R7", "flag set", irq_flag, 1);
    step();
    chk("R8", "exec", phase, 2);
    chk("R8", "blocked by flag", ret_wr_en, 0);
    step();
    chk("R8", "no jump", pc, 16'h0011);
    chk("R8", "flag kept", irq_flag, 1);
    irq_req = 1'b0; irq_return = 1'b1;
    step();
    chk("R9", "return outside exec", irq_flag, 1);
    irq_req = 1'b1;
    #0;
    chk("R9", "req with return not taken", ret_wr_en, 0);
    step();
    chk("R9", "flag cleared", irq_flag, 0);
    chk("R9", "pc", pc, 16'h0012);
    idle_ctrl();
    step();
    irq_req = 1'b1; branch_taken = 1'b1; branch_target = 16'h0030;
    #0;
    chk("R7", "resume is target", ret_wr_data, 16'h0030);
    step();
    idle_ctrl();
    chk("R7", "vector after branch", pc, VEC);
  endtask

  task automatic t_wrap();
    step();
    branch_taken = 1'b1; branch_target = 16'hFFFF;
    step();
    idle_ctrl();
    chk("R6", "pc at top", pc, 16'hFFFF);
    mem[63] = 16'h8000; mem[0] = 16'h1234;
    step();
    chk("R11", "wrap", pc, 16'h0000);
    chk("R3", "phase", phase, 1);
    step();
    chk("R11", "after wrap", pc, 16'h0001);
    chk("R3", "const", const_word, 16'h1234);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    t_reset();
    t_short();
    t_long();
    t_ignored_outside_exec();
    t_irq();
    t_wrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule